// File: doc/BRIEF.md
# JTAG Debug Memory Bridge

This block gives an external JTAG host word-level access to system memory. A standard test access port runs on TCK and decodes a 4-bit instruction. Three private instructions let the host set a word address, stream reads from memory, or write words while reading back the previous contents. Each completed memory shift becomes one or two bus transfers on a Wishbone-style master port in the system clock domain. The address then steps forward by one word.

Requests cross from TCK to the system clock with a toggle handshake. The request fields stay frozen until the system side hands back a completion toggle, which is synchronised into TCK. The read for the next shift is fetched ahead of time, so its data is ready to be captured when the host enters Capture-DR. The host must wait at least four TCK cycles in Run-Test/Idle after each instruction update and after each data update. This gives the bus transfer time to finish and its completion time to return. TCK is expected to run well below the system clock.

Top module: `jtag_mem_bridge`

## Requirements
- R1: Asserting trst_n low, or holding TMS high for five TCK rising edges, resets the TAP and selects the identification instruction (code 0001). A 32-bit data shift then returns 0x000018FF, LSB first, and a repeated shift returns the same value.
- R2: During an instruction shift, the 4-bit register shifts LSB first and first presents the captured value 0001 on TDO.
- R3: Codes other than 0001, 0101, 0110 and 0111 select a 1-bit bypass stage. It captures 0 and delays TDI by one TCK.
- R4: Code 0101 selects a 30-bit word-address register. Capture presents the current address and Update-DR loads the shifted-in value.
- R5: Under code 0111, each 32-bit shift outputs the word held at the current address and writes the shifted-in word to that address. The host must idle at least four TCK cycles in Run-Test/Idle after each update.
- R6: Under code 0110, each 32-bit shift outputs the word at the current address. The shifted-in bits are ignored and no bus write occurs.
- R7: After every completed memory shift under code 0110 or 0111, the address register increments by one.
- R8: A bus transfer keeps cyc and stb high together until ack. Address, write enable and write data stay stable while waiting. Each update issues at most one write, followed by one read.
- R9: TDO changes only on falling TCK edges and is 0 outside the Shift-IR and Shift-DR states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the bus side |
| sys_rst_n | input | 1 | Active-low reset, system domain |
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | Active-low asynchronous TAP reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | 30 | Bus word address |
| wb_dat_o | output | 32 | Bus write data |
| wb_dat_i | input | 32 | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
Every memory location in the bench starts with a distinct address-derived word. This means that any read-back from the wrong address, or a missed increment, shows up as a wrong value. Write-with-readback streams distinct words through consecutive addresses. A following read-only pass with junk on TDI then separates "old value returned" from "new value written", and shows that reads write nothing. Address captures after each pass confirm that the address advanced. Identification shifts after trst_n and after a TMS-only reset, an instruction capture, and bypass shifts with two different unused codes check the TAP framing. Every system clock also checks the bus hold rules.

// File: rtl/jmb_pkg.sv
package jmb_pkg;
    localparam int IR_W   = 4;
    localparam int ADDR_W = 30;
    localparam int DATA_W = 32;
    localparam logic [DATA_W-1:0] ID_WORD = 32'h0000_18FF;
    localparam logic [IR_W-1:0] OP_IDENT = 4'b0001;
    localparam logic [IR_W-1:0] OP_ADDR  = 4'b0101;
    localparam logic [IR_W-1:0] OP_RDMEM = 4'b0110;
    localparam logic [IR_W-1:0] OP_WRMEM = 4'b0111;
    localparam logic [IR_W-1:0] IR_CAPT  = 4'b0001;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI, ST_SELDR, ST_CAPDR, ST_SHDR, ST_EX1DR, ST_PADR, ST_EX2DR,
        ST_UPDR, ST_SELIR, ST_CAPIR, ST_SHIR, ST_EX1IR, ST_PAIR, ST_EX2IR, ST_UPIR
    } tap_st_e;

    typedef enum logic [1:0] {SEL_IDENT, SEL_ADDR, SEL_MEM, SEL_BYP} dr_sel_e;

    typedef enum logic [1:0] {WB_IDLE, WB_WRITE, WB_READ} wb_st_e;

    typedef struct packed {
        logic [IR_W-1:0]   ir;
        logic [IR_W-1:0]   ir_sr;
        logic [DATA_W-1:0] dr_sr;
        logic [ADDR_W-1:0] addr;
        logic              req_tog;
        logic              req_we;
        logic [ADDR_W-1:0] wr_adr;
        logic [ADDR_W-1:0] rd_adr;
        logic [DATA_W-1:0] wdata;
        logic              ack_s1;
        logic              ack_s2;
    } tck_regs_t;

    typedef struct packed {
        wb_st_e            st;
        logic              req_s1;
        logic              req_s2;
        logic              req_seen;
        logic              ack_tog;
        logic [DATA_W-1:0] rd_word;
        logic              cyc;
        logic              we;
        logic [ADDR_W-1:0] adr;
        logic [DATA_W-1:0] dat;
    } wb_regs_t;

    function automatic tap_st_e tap_step(tap_st_e s, logic m);
        case (s)
            ST_TLR:   return m ? ST_TLR   : ST_RTI;
            ST_RTI:   return m ? ST_SELDR : ST_RTI;
            ST_SELDR: return m ? ST_SELIR : ST_CAPDR;
            ST_CAPDR: return m ? ST_EX1DR : ST_SHDR;
            ST_SHDR:  return m ? ST_EX1DR : ST_SHDR;
            ST_EX1DR: return m ? ST_UPDR  : ST_PADR;
            ST_PADR:  return m ? ST_EX2DR : ST_PADR;
            ST_EX2DR: return m ? ST_UPDR  : ST_SHDR;
            ST_UPDR:  return m ? ST_SELDR : ST_RTI;
            ST_SELIR: return m ? ST_TLR   : ST_CAPIR;
            ST_CAPIR: return m ? ST_EX1IR : ST_SHIR;
            ST_SHIR:  return m ? ST_EX1IR : ST_SHIR;
            ST_EX1IR: return m ? ST_UPIR  : ST_PAIR;
            ST_PAIR:  return m ? ST_EX2IR : ST_PAIR;
            ST_EX2IR: return m ? ST_UPIR  : ST_SHIR;
            default:  return m ? ST_SELDR : ST_RTI;
        endcase
    endfunction

    function automatic dr_sel_e decode_op(logic [IR_W-1:0] op);
        case (op)
            OP_IDENT: return SEL_IDENT;
            OP_ADDR:  return SEL_ADDR;
            OP_RDMEM, OP_WRMEM: return SEL_MEM;
            default:  return SEL_BYP;
        endcase
    endfunction
endpackage

// File: rtl/jmb_tap_fsm.sv
module jmb_tap_fsm
    import jmb_pkg::*;
(
    input  logic    tck,
    input  logic    trst_n,
    input  logic    tms,
    output tap_st_e state
);
    tap_st_e state_d, state_q;

    always_comb begin
        state_d = tap_step(state_q, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_TLR;
        else         state_q <= state_d;
    end

    assign state = state_q;

    // R1: five TMS-high edges always land in Test-Logic-Reset
    p_tms_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
            |-> state_q == ST_TLR);
endmodule

// File: rtl/jmb_tck_regs.sv
module jmb_tck_regs
    import jmb_pkg::*;
(
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  tap_st_e           state,
    input  logic              ack_tog,
    input  logic [DATA_W-1:0] rd_word,
    output logic              tdo,
    output logic              req_tog,
    output logic              req_we,
    output logic [ADDR_W-1:0] wr_adr,
    output logic [ADDR_W-1:0] rd_adr,
    output logic [DATA_W-1:0] wdata
);
    tck_regs_t r_d, r_q;
    logic      tdo_d, tdo_q;
    dr_sel_e   sel;
    logic [DATA_W-1:0] shifted;

    assign sel = decode_op(r_q.ir);

    always_comb begin
        r_d        = r_q;
        r_d.ack_s1 = ack_tog;
        r_d.ack_s2 = r_q.ack_s1;
        shifted    = r_q.dr_sr >> 1;
        case (sel)
            SEL_IDENT, SEL_MEM: shifted[DATA_W-1] = tdi;
            SEL_ADDR:           shifted[ADDR_W-1] = tdi;
            default:            shifted[0]        = tdi;
        endcase
        case (state)
            ST_TLR:   r_d.ir = OP_IDENT;
            ST_CAPIR: r_d.ir_sr = IR_CAPT;
            ST_SHIR:  r_d.ir_sr = {tdi, r_q.ir_sr[IR_W-1:1]};
            ST_UPIR: begin
                r_d.ir = r_q.ir_sr;
                if (decode_op(r_q.ir_sr) == SEL_MEM) begin
                    r_d.req_tog = ~r_q.req_tog;
                    r_d.req_we  = 1'b0;
                    r_d.rd_adr  = r_q.addr;
                end
            end
            ST_CAPDR: begin
                case (sel)
                    SEL_IDENT: r_d.dr_sr = ID_WORD;
                    SEL_ADDR:  r_d.dr_sr = DATA_W'(r_q.addr);
                    SEL_MEM:   r_d.dr_sr = rd_word;
                    default:   r_d.dr_sr = '0;
                endcase
            end
            ST_SHDR: r_d.dr_sr = shifted;
            ST_UPDR: begin
                if (sel == SEL_ADDR) begin
                    r_d.addr = r_q.dr_sr[ADDR_W-1:0];
                end else if (sel == SEL_MEM) begin
                    r_d.req_tog = ~r_q.req_tog;
                    r_d.req_we  = (r_q.ir == OP_WRMEM);
                    r_d.wr_adr  = r_q.addr;
                    r_d.wdata   = r_q.dr_sr;
                    r_d.rd_adr  = r_q.addr + 1'b1;
                    r_d.addr    = r_q.addr + 1'b1;
                end
            end
            default: ;
        endcase
        tdo_d = (state == ST_SHIR) ? r_q.ir_sr[0] :
                (state == ST_SHDR) ? r_q.dr_sr[0] : 1'b0;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q    <= '0;
            r_q.ir <= OP_IDENT;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) tdo_q <= 1'b0;
        else         tdo_q <= tdo_d;
    end

    assign tdo     = tdo_q;
    assign req_tog = r_q.req_tog;
    assign req_we  = r_q.req_we;
    assign wr_adr  = r_q.wr_adr;
    assign rd_adr  = r_q.rd_adr;
    assign wdata   = r_q.wdata;

    // R7: memory update steps the word address by one
    p_addr_step_r7: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_UPDR && (r_q.ir == OP_RDMEM || r_q.ir == OP_WRMEM))
            |=> r_q.addr == $past(r_q.addr) + 1'b1);
    // R8: a new request only follows an update state
    p_req_source_r8: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(r_q.req_tog) |-> ($past(state) == ST_UPDR || $past(state) == ST_UPIR));
    // R5: completion has come back before memory data is captured
    p_done_before_capture_r5: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAPDR && sel == SEL_MEM) |-> r_q.ack_s2 == r_q.req_tog);
endmodule

// File: rtl/jmb_wb_master.sv
module jmb_wb_master
    import jmb_pkg::*;
(
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              req_tog,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] wr_adr,
    input  logic [ADDR_W-1:0] rd_adr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack_tog,
    output logic [DATA_W-1:0] rd_word,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [ADDR_W-1:0] wb_adr,
    output logic [DATA_W-1:0] wb_dat_w,
    input  logic [DATA_W-1:0] wb_dat_r,
    input  logic              wb_ack
);
    wb_regs_t w_d, w_q;

    always_comb begin
        w_d        = w_q;
        w_d.req_s1 = req_tog;
        w_d.req_s2 = w_q.req_s1;
        case (w_q.st)
            WB_IDLE: begin
                if (w_q.req_s2 != w_q.req_seen) begin
                    w_d.req_seen = w_q.req_s2;
                    w_d.cyc      = 1'b1;
                    w_d.we       = req_we;
                    w_d.adr      = req_we ? wr_adr : rd_adr;
                    w_d.dat      = wdata;
                    w_d.st       = req_we ? WB_WRITE : WB_READ;
                end
            end
            WB_WRITE: begin
                if (wb_ack) begin
                    w_d.we  = 1'b0;
                    w_d.adr = rd_adr;
                    w_d.st  = WB_READ;
                end
            end
            default: begin
                if (wb_ack) begin
                    w_d.rd_word = wb_dat_r;
                    w_d.cyc     = 1'b0;
                    w_d.ack_tog = ~w_q.ack_tog;
                    w_d.st      = WB_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) w_q <= '0;
        else            w_q <= w_d;
    end

    assign ack_tog  = w_q.ack_tog;
    assign rd_word  = w_q.rd_word;
    assign wb_cyc   = w_q.cyc;
    assign wb_stb   = w_q.cyc;
    assign wb_we    = w_q.we;
    assign wb_adr   = w_q.adr;
    assign wb_dat_w = w_q.dat;

    // R8: an unacknowledged transfer holds its request
    p_hold_until_ack_r8: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (wb_cyc && !wb_ack) |=> (wb_cyc && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dat_w)));
    // R8: completion is only reported after an acknowledged read
    p_done_after_read_r8: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !$stable(ack_tog) |-> $past(wb_cyc && wb_ack && !wb_we));
endmodule

// File: rtl/jtag_mem_bridge.sv
module jtag_mem_bridge
    import jmb_pkg::*;
(
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack_i
);
    tap_st_e           state;
    logic              req_tog, req_we, ack_tog;
    logic [ADDR_W-1:0] wr_adr, rd_adr;
    logic [DATA_W-1:0] wdata, rd_word;

    jmb_tap_fsm u_tap (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
    );

    jmb_tck_regs u_regs (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
        .ack_tog(ack_tog), .rd_word(rd_word), .tdo(tdo),
        .req_tog(req_tog), .req_we(req_we), .wr_adr(wr_adr),
        .rd_adr(rd_adr), .wdata(wdata)
    );

    jmb_wb_master u_wb (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
        .req_tog(req_tog), .req_we(req_we), .wr_adr(wr_adr),
        .rd_adr(rd_adr), .wdata(wdata), .ack_tog(ack_tog), .rd_word(rd_word),
        .wb_cyc(wb_cyc_o), .wb_stb(wb_stb_o), .wb_we(wb_we_o),
        .wb_adr(wb_adr_o), .wb_dat_w(wb_dat_o), .wb_dat_r(wb_dat_i),
        .wb_ack(wb_ack_i)
    );
endmodule

// File: tb/jtag_mem_bridge_tb.sv
module jtag_mem_bridge_tb_top;
    localparam int TCK_HALF = 50;

    logic        sys_clk = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic        tdo;
    logic        wb_cyc, wb_stb, wb_we, wb_ack = 1'b0;
    logic [29:0] wb_adr;
    logic [31:0] wb_dat_o, wb_dat_i = '0;

    int n_checks = 0, n_fail = 0, n_writes = 0;
    bit done = 0;
    bit [31:0] mem_m [int];
    bit [31:0] exp_m [int];
    int model_addr = 0;

    always #2.5 sys_clk = ~sys_clk;

    jtag_mem_bridge dut_i (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .tck(tck), .trst_n(trst_n),
        .tms(tms), .tdi(tdi), .tdo(tdo), .wb_cyc_o(wb_cyc), .wb_stb_o(wb_stb),
        .wb_we_o(wb_we), .wb_adr_o(wb_adr), .wb_dat_o(wb_dat_o),
        .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack)
    );

    function automatic bit [31:0] seed_word(int a);
        return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
    endfunction

    function automatic bit [31:0] mem_rd(int a);
        return mem_m.exists(a) ? mem_m[a] : seed_word(a);
    endfunction

    function automatic bit [31:0] exp_rd(int a);
        return exp_m.exists(a) ? exp_m[a] : seed_word(a);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: one-cycle registered acknowledge
    always @(posedge sys_clk) begin
        if (wb_cyc && wb_stb && !wb_ack) begin
            wb_ack <= 1'b1;
            if (wb_we) begin
                mem_m[int'(wb_adr)] = wb_dat_o;
                n_writes++;
            end else begin
                wb_dat_i <= mem_rd(int'(wb_adr));
            end
        end else begin
            wb_ack <= 1'b0;
        end
    end

    // Per-clock bus protocol comparison (R8)
    logic        p_wait = 1'b0;
    logic [29:0] p_adr;
    logic        p_we;
    logic [31:0] p_dat;
    always @(negedge sys_clk) begin
        if (sys_rst_n && !done) begin
            check(wb_stb == wb_cyc, "R8 stb/cyc", {31'd0, wb_stb}, {31'd0, wb_cyc});
            if (p_wait)
                check(wb_cyc && wb_adr == p_adr && wb_we == p_we && wb_dat_o == p_dat,
                      "R8 hold", {2'd0, wb_adr}, {2'd0, p_adr});
            p_wait = wb_cyc && !wb_ack;
            p_adr  = wb_adr;
            p_we   = wb_we;
            p_dat  = wb_dat_o;
        end
    end

    task automatic tck_cycle(input logic m, input logic d, output logic o);
        logic after;
        tms = m;
        tdi = d;
        #(TCK_HALF);
        o = tdo;
        tck = 1'b1;
        #1;
        after = tdo;
        check(after === o, "R9 tdo stable at rising edge", {31'd0, after}, {31'd0, o});
        #(TCK_HALF - 1);
        tck = 1'b0;
    endtask

    task automatic idle(int n);
        logic o;
        for (int i = 0; i < n; i++) tck_cycle(1'b0, 1'b0, o);
    endtask

    task automatic shift_ir(input logic [3:0] code, output logic [3:0] out);
        logic o;
        tck_cycle(1'b1, 1'b0, o);
        tck_cycle(1'b1, 1'b0, o);
        tck_cycle(1'b0, 1'b0, o);
        tck_cycle(1'b0, 1'b0, o);
        for (int i = 0; i < 4; i++) begin
            tck_cycle(i == 3, code[i], o);
            out[i] = o;
        end
        tck_cycle(1'b1, 1'b0, o);
        tck_cycle(1'b0, 1'b0, o);
        idle(6);
    endtask

    task automatic shift_dr(input int len, input logic [31:0] din, output logic [31:0] out);
        logic o;
        out = '0;
        tck_cycle(1'b1, 1'b0, o);
        tck_cycle(1'b0, 1'b0, o);
        tck_cycle(1'b0, 1'b0, o);
        for (int i = 0; i < len; i++) begin
            tck_cycle(i == len - 1, din[i], o);
            out[i] = o;
        end
        tck_cycle(1'b1, 1'b0, o);
        tck_cycle(1'b0, 1'b0, o);
        idle(6);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge sys_clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        logic [3:0]  ir_out;
        int wr_before;
        bit [31:0] words [3];
        words[0] = 32'hDEAD_0001;
        words[1] = 32'h1234_5678;
        words[2] = 32'h0F0F_F0F0;

        #40;
        sys_rst_n = 1'b1;
        trst_n    = 1'b1;
        #7;
        check(tdo === 1'b0, "R9 tdo low after reset", {31'd0, tdo}, 32'd0);
        tck_cycle(1'b0, 1'b0, ir_out[0]);
        idle(2);
        check(tdo === 1'b0, "R9 tdo low in idle", {31'd0, tdo}, 32'd0);

        // R1: identification after trst_n, twice
        shift_dr(32, 32'hFFFF_FFFF, r);
        check(r == 32'h0000_18FF, "R1 ident", r, 32'h0000_18FF);
        shift_dr(32, 32'h0, r);
        check(r == 32'h0000_18FF, "R1 ident repeat", r, 32'h0000_18FF);

        // R2: instruction capture pattern, R3: bypass with 1111
        shift_ir(4'b1111, ir_out);
        check(ir_out == 4'b0001, "R2 ir capture", {28'd0, ir_out}, 32'd1);
        shift_dr(8, 32'h0000_00B4, r);
        check(r[7:0] == 8'h68, "R3 bypass 1111", {24'd0, r[7:0]}, 32'h68);
        shift_ir(4'b0000, ir_out);
        shift_dr(8, 32'h0000_0053, r);
        check(r[7:0] == 8'hA6, "R3 bypass 0000", {24'd0, r[7:0]}, 32'hA6);

        // R1: TMS-only reset back to identification
        for (int i = 0; i < 5; i++) tck_cycle(1'b1, 1'b0, ir_out[0]);
        tck_cycle(1'b0, 1'b0, ir_out[0]);
        shift_dr(32, 32'h0, r);
        check(r == 32'h0000_18FF, "R1 ident after tms reset", r, 32'h0000_18FF);

        // R4: address register
        shift_ir(4'b0101, ir_out);
        shift_dr(30, 32'd5, r);
        check(r[29:0] == 30'd0, "R4 addr capture reset", {2'd0, r[29:0]}, 32'd0);
        shift_dr(30, 32'd9, r);
        check(r[29:0] == 30'd5, "R4 addr capture loaded", {2'd0, r[29:0]}, 32'd5);
        model_addr = 9;

        // R5: write with readback, R7 increments
        shift_ir(4'b0111, ir_out);
        for (int i = 0; i < 3; i++) begin
            bit [31:0] e;
            e = exp_rd(model_addr);
            shift_dr(32, words[i], r);
            check(r == e, "R5 old word out", r, e);
            exp_m[model_addr] = words[i];
            model_addr++;
        end
        check(n_writes == 3, "R5 write count", n_writes, 3);
        shift_ir(4'b0101, ir_out);
        shift_dr(30, 32'd9, r);
        check(r[29:0] == 30'(model_addr), "R7 addr after writes", {2'd0, r[29:0]}, model_addr);
        model_addr = 9;

        // R6: read-only returns written words, ignores TDI, writes nothing
        wr_before = n_writes;
        shift_ir(4'b0110, ir_out);
        for (int i = 0; i < 4; i++) begin
            bit [31:0] e;
            e = exp_rd(model_addr);
            shift_dr(32, 32'hFFFF_0000 ^ i, r);
            check(r == e, "R6 read word", r, e);
            model_addr++;
        end
        check(n_writes == wr_before, "R6 no write", n_writes, wr_before);
        shift_ir(4'b0101, ir_out);
        shift_dr(30, 32'd10, r);
        check(r[29:0] == 30'(model_addr), "R7 addr after reads", {2'd0, r[29:0]}, model_addr);
        model_addr = 10;

        // R6 via readback: earlier reads left memory untouched
        shift_ir(4'b0111, ir_out);
        shift_dr(32, 32'hCAFE_F00D, r);
        check(r == exp_rd(10), "R6 memory unchanged", r, exp_rd(10));

        finish_run();
    end
endmodule